// File: doc/BRIEF.md
# Dual-Rate Cell Shaper Bank

This block holds a bank of independent traffic shapers, one per group of channels, and decides on every scheduling tick which shaper may emit a cell. Each shaper keeps two counting buckets: one enforces a peak cell rate and the other a sustained, average rate. A bucket drains by a programmed amount on every tick and fills by a programmed charge each time its shaper is granted a cell. A shaper may send only when it is switched on and both of its buckets are at or below their programmed limits.

Among the shapers allowed to send on a tick, the one with the largest priority value is granted. Equal-priority contenders take turns in round-robin order. The granted shaper's two buckets are charged on that same tick. A host programs every shaper's charges, drain amounts, limits, priority and on/off flag through a simple write port. It may do so while traffic runs, and a write never clears the bucket levels. Channel queues and the cell datapath sit outside this block. They use the grant to pick which channel to serve.

Top module: `shaper_bank`

## Requirements
- R1: While `rst_n` is low at a clock edge, all bucket levels and all programmed values (including priority and the on/off flag) become zero, and `elig_o`, `grant_vld_o` and `grant_idx_o` become zero. After reset, a tick with no programming grants nothing.
- R2: A clock edge with `wr_en_i` high stores `wr_data_i` into shaper `wr_idx_i`. The field is selected by `wr_field_i`: 0 peak charge, 1 peak drain, 2 peak limit, 3 average charge, 4 average drain, 5 average limit, 6 priority (low PRIO_W data bits), 7 on/off flag (data bit 0). A write leaves the bucket levels untouched. Its effect is first seen on the outputs after the next tick.
- R3: On a tick, a shaper is eligible when its flag is set, its peak level is at or below the peak limit, and its average level is at or below the average limit. These levels are the ones held before that tick's update. At the clock edge where `tick_i` is high, `elig_o` is loaded with this per-shaper result, bit i for shaper i.
- R4: On every tick, each bucket level drops by its drain amount, stopping at zero.
- R5: On a tick where a shaper is granted, each of its buckets adds its charge after the drain. The result saturates at 2^CNT_W-1 and does not wrap.
- R6: At the tick edge, `grant_vld_o` is set if any shaper is eligible. `grant_idx_o` then names an eligible shaper whose priority value is the largest among the eligible ones.
- R7: Among eligible shapers that share the largest priority, the grant goes to the first one found by scanning upward (cyclically) from the index after the last granted shaper. After reset, the scan starts at shaper 0.
- R8: `grant_vld_o` is high for exactly the one cycle after a tick edge. Between ticks, the bucket levels, `elig_o` and `grant_idx_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_i | input | 1 | Scheduling tick strobe |
| wr_en_i | input | 1 | Host parameter write strobe |
| wr_idx_i | input | IDX_W | Shaper addressed by the write |
| wr_field_i | input | 3 | Parameter field code (see R2) |
| wr_data_i | input | CNT_W | Value written |
| elig_o | output | NUM_SHAPERS | Per-shaper eligibility from the last tick |
| grant_vld_o | output | 1 | One-cycle pulse: a shaper was granted on the last tick |
| grant_idx_o | output | IDX_W | Index of the granted shaper |

## Verification
Properties check on every cycle that a grant only names an eligible shaper with no eligible shaper of higher priority, that the grant pulse follows a tick, and that bucket levels stay frozen between ticks. They also check that a level never rises on a tick without a charge and never falls on a charged tick whose charge covers the drain, which rules out wrap-around. The exact rate patterns cannot be seen from single-cycle relations and are left to the bench's scenarios. These are the one-in-three peak spacing, the average-bucket burst recovery, the round-robin order among equal priorities, the effect of live rewrites, and saturation at the counter ceiling.

// File: rtl/shaper_pkg.sv
// Package: shared field codes for the shaper bank host write port.
// Assumes a 3-bit field selector; codes 0..5 address the two buckets
// (bucket b uses codes 3*b + {0 charge, 1 drain, 2 limit}).
package shaper_pkg;

    typedef enum logic [2:0] {
        FLD_PK_CHARGE = 3'd0,
        FLD_PK_DRAIN  = 3'd1,
        FLD_PK_LIMIT  = 3'd2,
        FLD_AV_CHARGE = 3'd3,
        FLD_AV_DRAIN  = 3'd4,
        FLD_AV_LIMIT  = 3'd5,
        FLD_PRIORITY  = 3'd6,
        FLD_ENABLE    = 3'd7
    } shaper_field_e;

    localparam int unsigned FIELDS_PER_BUCKET = 3;
    localparam int unsigned NUM_BUCKETS       = 2;

endpackage

// File: rtl/shaper_bucket.sv
// Module: shaper_bucket
// One leaky bucket level. On each tick the level drops by the drain amount
// (floor zero), then adds the charge when charge_en_i is set (ceiling all
// ones). conform_o reports level <= limit using the pre-update level.
// Assumes tick_i, charge_en_i and the amounts are stable around the edge.
module shaper_bucket #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             charge_en_i,
    input  logic [CNT_W-1:0] charge_i,
    input  logic [CNT_W-1:0] drain_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             conform_o
);

    logic [CNT_W-1:0] level_q;
    logic [CNT_W-1:0] drained;
    logic [CNT_W:0]   sum_wide;
    logic [CNT_W-1:0] level_d;

    // Next level: drain with floor, then optional charge with ceiling.
    always_comb begin
        drained  = (level_q > drain_i) ? (level_q - drain_i) : '0;
        sum_wide = {1'b0, drained} + {1'b0, (charge_en_i ? charge_i : '0)};
        level_d  = sum_wide[CNT_W] ? {CNT_W{1'b1}} : sum_wide[CNT_W-1:0];
    end

    // Level register, updated only on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
        end else if (tick_i) begin
            level_q <= level_d;
        end
    end

    // Conformance against the programmed limit.
    assign conform_o = (level_q <= limit_i);

    assert_level_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(level_q));

    assert_no_rise_uncharged_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !charge_en_i) |=> (level_q <= $past(level_q)));

    assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && charge_en_i && (charge_i >= drain_i)) |=> (level_q >= $past(level_q)));

endmodule

// File: rtl/shaper_slot.sv
// Module: shaper_slot
// One shaper: its programmed values (per bucket charge/drain/limit, priority,
// on/off flag) plus a peak and an average bucket. Writes addressed to
// SLOT_ID update the stored values without touching the bucket levels.
// elig_o is combinational from the current levels and stored values.
module shaper_slot
    import shaper_pkg::*;
#(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned PRIO_W  = 2,
    parameter int unsigned IDX_W   = 4,
    parameter int unsigned SLOT_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              grant_i,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [2:0]        wr_field_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    output logic              elig_o,
    output logic [PRIO_W-1:0] prio_o
);

    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(SLOT_ID);

    logic                   hit;
    logic [NUM_BUCKETS-1:0] conform;
    logic [PRIO_W-1:0]      prio_q;
    logic                   enable_q;

    assign hit = wr_en_i && (wr_idx_i == MY_IDX);

    // Priority and on/off flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q   <= '0;
            enable_q <= 1'b0;
        end else if (hit) begin
            if (wr_field_i == FLD_PRIORITY) prio_q   <= wr_data_i[PRIO_W-1:0];
            if (wr_field_i == FLD_ENABLE)   enable_q <= wr_data_i[0];
        end
    end

    for (genvar b = 0; b < NUM_BUCKETS; b++) begin : g_bucket
        localparam logic [2:0] F_CHG = 3'(b * FIELDS_PER_BUCKET);
        localparam logic [2:0] F_DRN = 3'(b * FIELDS_PER_BUCKET + 1);
        localparam logic [2:0] F_LIM = 3'(b * FIELDS_PER_BUCKET + 2);

        logic [CNT_W-1:0] charge_q;
        logic [CNT_W-1:0] drain_q;
        logic [CNT_W-1:0] limit_q;

        // Per-bucket programmed amounts.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                charge_q <= '0;
                drain_q  <= '0;
                limit_q  <= '0;
            end else if (hit) begin
                if (wr_field_i == F_CHG) charge_q <= wr_data_i;
                if (wr_field_i == F_DRN) drain_q  <= wr_data_i;
                if (wr_field_i == F_LIM) limit_q  <= wr_data_i;
            end
        end

        shaper_bucket #(.CNT_W(CNT_W)) u_bucket (
            .clk         (clk),
            .rst_n       (rst_n),
            .tick_i      (tick_i),
            .charge_en_i (grant_i),
            .charge_i    (charge_q),
            .drain_i     (drain_q),
            .limit_i     (limit_q),
            .conform_o   (conform[b])
        );
    end

    // Eligible only when switched on and every bucket conforms.
    assign elig_o = enable_q && (&conform);
    assign prio_o = prio_q;

endmodule

// File: rtl/shaper_arbiter.sv
// Module: shaper_arbiter
// Picks, among eligible requesters, one with the largest priority value;
// ties resolved by scanning cyclically from the index after the last winner.
// The last-winner pointer advances only on a tick that produces a winner.
// Result is combinational; assumes NUM >= 2.
module shaper_arbiter #(
    parameter int unsigned NUM    = 16,
    parameter int unsigned PRIO_W = 2,
    parameter int unsigned IDX_W  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick_i,
    input  logic [NUM-1:0]             elig_i,
    input  logic [NUM-1:0][PRIO_W-1:0] prio_i,
    output logic                       win_vld_o,
    output logic [IDX_W-1:0]           win_idx_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM - 1);

    logic [IDX_W-1:0]  last_q;
    logic [IDX_W-1:0]  start_idx;
    logic [PRIO_W-1:0] top_prio;

    // Highest priority among eligible requesters.
    always_comb begin
        top_prio = '0;
        for (int i = 0; i < NUM; i++) begin
            if (elig_i[i] && (prio_i[i] > top_prio)) top_prio = prio_i[i];
        end
    end

    assign start_idx = (last_q == LAST_IDX) ? '0 : (last_q + 1'b1);

    // Cyclic scan for the first top-priority eligible requester.
    always_comb begin
        win_vld_o = 1'b0;
        win_idx_o = '0;
        for (int k = 0; k < NUM; k++) begin
            int j;
            j = (int'(start_idx) + k) % NUM;
            if (!win_vld_o && elig_i[j] && (prio_i[j] == top_prio)) begin
                win_vld_o = 1'b1;
                win_idx_o = IDX_W'(j);
            end
        end
    end

    // Last-winner pointer for round-robin fairness.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= LAST_IDX;
        end else if (tick_i && win_vld_o) begin
            last_q <= win_idx_o;
        end
    end

    logic outranked;
    // Independent check: does any eligible requester beat the winner?
    always_comb begin
        outranked = 1'b0;
        for (int i = 0; i < NUM; i++) begin
            if (elig_i[i] && (prio_i[i] > prio_i[win_idx_o])) outranked = 1'b1;
        end
    end

    assert_winner_top_prio_R6: assert property (@(posedge clk) disable iff (!rst_n)
        win_vld_o |-> !outranked);

    assert_winner_eligible_R6: assert property (@(posedge clk) disable iff (!rst_n)
        win_vld_o |-> elig_i[win_idx_o]);

endmodule

// File: rtl/shaper_bank.sv
// Module: shaper_bank (top)
// Bank of NUM_SHAPERS dual-bucket shapers with priority / round-robin grant.
// On each tick it registers the eligibility vector and the grant, and
// charges the granted shaper's buckets. Assumes NUM_SHAPERS >= 2 and that
// host writes and ticks are single-cycle strobes.
module shaper_bank #(
    parameter int unsigned NUM_SHAPERS = 16,
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned PRIO_W      = 2,
    localparam int unsigned IDX_W      = $clog2(NUM_SHAPERS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick_i,
    input  logic                   wr_en_i,
    input  logic [IDX_W-1:0]       wr_idx_i,
    input  logic [2:0]             wr_field_i,
    input  logic [CNT_W-1:0]       wr_data_i,
    output logic [NUM_SHAPERS-1:0] elig_o,
    output logic                   grant_vld_o,
    output logic [IDX_W-1:0]       grant_idx_o
);

    logic [NUM_SHAPERS-1:0]             elig_now;
    logic [NUM_SHAPERS-1:0][PRIO_W-1:0] prio_all;
    logic                               win_vld;
    logic [IDX_W-1:0]                   win_idx;

    for (genvar s = 0; s < NUM_SHAPERS; s++) begin : g_slot
        logic slot_grant;
        assign slot_grant = tick_i && win_vld && (win_idx == IDX_W'(s));

        shaper_slot #(
            .CNT_W   (CNT_W),
            .PRIO_W  (PRIO_W),
            .IDX_W   (IDX_W),
            .SLOT_ID (s)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick_i     (tick_i),
            .grant_i    (slot_grant),
            .wr_en_i    (wr_en_i),
            .wr_idx_i   (wr_idx_i),
            .wr_field_i (wr_field_i),
            .wr_data_i  (wr_data_i),
            .elig_o     (elig_now[s]),
            .prio_o     (prio_all[s])
        );
    end

    shaper_arbiter #(
        .NUM    (NUM_SHAPERS),
        .PRIO_W (PRIO_W),
        .IDX_W  (IDX_W)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .elig_i    (elig_now),
        .prio_i    (prio_all),
        .win_vld_o (win_vld),
        .win_idx_o (win_idx)
    );

    // Output registers: capture eligibility and grant on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elig_o      <= '0;
            grant_vld_o <= 1'b0;
            grant_idx_o <= '0;
        end else if (tick_i) begin
            elig_o      <= elig_now;
            grant_vld_o <= win_vld;
            grant_idx_o <= win_idx;
        end else begin
            grant_vld_o <= 1'b0;
        end
    end

    assert_grant_names_eligible_R6: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld_o |-> elig_o[grant_idx_o]);

    assert_grant_follows_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld_o |-> $past(tick_i));

endmodule

// File: tb/shaper_bank_tb.sv
module shaper_bank_tb_top;

    localparam int N     = 16;
    localparam int CW    = 16;
    localparam int IW    = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          tick_i;
    logic          wr_en_i;
    logic [IW-1:0] wr_idx_i;
    logic [2:0]    wr_field_i;
    logic [CW-1:0] wr_data_i;
    logic [N-1:0]  elig_o;
    logic          grant_vld_o;
    logic [IW-1:0] grant_idx_o;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    shaper_bank dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .wr_en_i     (wr_en_i),
        .wr_idx_i    (wr_idx_i),
        .wr_field_i  (wr_field_i),
        .wr_data_i   (wr_data_i),
        .elig_o      (elig_o),
        .grant_vld_o (grant_vld_o),
        .grant_idx_o (grant_idx_o)
    );

    // Per-tick expectations for the peak-spacing scenario: {elig, vld, idx}.
    localparam logic [20:0] PEAK_TBL [0:5] = '{
        {16'h0003, 1'b1, 4'd0},
        {16'h0002, 1'b1, 4'd1},
        {16'h0000, 1'b0, 4'd0},
        {16'h0003, 1'b1, 4'd0},
        {16'h0002, 1'b1, 4'd1},
        {16'h0000, 1'b0, 4'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input int idx, input int fld, input int data);
        @(negedge clk);
        wr_en_i    = 1'b1;
        wr_idx_i   = IW'(idx);
        wr_field_i = 3'(fld);
        wr_data_i  = CW'(data);
        @(negedge clk);
        wr_en_i    = 1'b0;
    endtask

    // Pulse one tick; returns with outputs sampled at the following negedge.
    task automatic do_tick();
        @(negedge clk);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic tick_chk(input string req, input logic vld, input int idx);
        do_tick();
        chk(req, 32'(grant_vld_o), 32'(vld));
        if (vld) chk(req, 32'(grant_idx_o), 32'(idx));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; tick_i = 1'b0; wr_en_i = 1'b0;
        wr_idx_i = '0; wr_field_i = '0; wr_data_i = '0;
        do_reset();

        // R1: reset state and an unprogrammed tick
        chk("R1 elig", 32'(elig_o), 0);
        chk("R1 vld", 32'(grant_vld_o), 0);
        chk("R1 idx", 32'(grant_idx_o), 0);
        do_tick();
        chk("R1 idle tick vld", 32'(grant_vld_o), 0);

        // R2/R3/R4/R5/R6: peak spacing scenario driven from the table
        wr(0, 6, 1); wr(0, 0, 2); wr(0, 1, 1); wr(0, 7, 1);
        wr(1, 0, 1); wr(1, 1, 1); wr(1, 7, 1);
        for (int t = 0; t < 6; t++) begin
            do_tick();
            chk("R3 table elig", 32'(elig_o), 32'(PEAK_TBL[t][20:5]));
            chk("R6 table vld", 32'(grant_vld_o), 32'(PEAK_TBL[t][4]));
            if (PEAK_TBL[t][4]) chk("R6 table idx", 32'(grant_idx_o), 32'(PEAK_TBL[t][3:0]));
        end

        // R1: reset mid-run clears programming
        do_reset();
        do_tick();
        chk("R1 after rerun elig", 32'(elig_o), 0);

        // R6/R7: priorities, round robin among equals
        wr(3, 6, 1); wr(3, 7, 1);
        wr(5, 6, 2); wr(5, 7, 1);
        wr(9, 6, 2); wr(9, 7, 1);
        tick_chk("R7 first", 1'b1, 5);
        chk("R3 elig mask", 32'(elig_o), 32'h0228);
        tick_chk("R7 second", 1'b1, 9);
        tick_chk("R7 wrap", 1'b1, 5);

        // R8: nothing moves between ticks
        @(negedge clk);
        chk("R8 vld pulse", 32'(grant_vld_o), 0);
        repeat (3) @(negedge clk);
        chk("R8 elig hold", 32'(elig_o), 32'h0228);
        chk("R8 idx hold", 32'(grant_idx_o), 5);

        // R2: live write, visible only after the next tick
        wr(5, 7, 0);
        chk("R2 before tick", 32'(elig_o), 32'h0228);
        tick_chk("R2 disabled", 1'b1, 9);
        chk("R2 elig after", 32'(elig_o), 32'h0208);
        tick_chk("R6 alone", 1'b1, 9);
        wr(3, 6, 3);
        tick_chk("R6 raised prio", 1'b1, 3);

        // R3/R4: average bucket burst then recovery
        do_reset();
        wr(0, 3, 4); wr(0, 4, 1); wr(0, 5, 2); wr(0, 7, 1);
        tick_chk("R3 avg t1", 1'b1, 0);
        tick_chk("R3 avg t2", 1'b0, 0);
        tick_chk("R4 avg t3", 1'b0, 0);
        tick_chk("R4 avg t4", 1'b1, 0);
        tick_chk("R4 avg t5", 1'b0, 0);

        // R5: saturation at the counter ceiling; R2 write keeps level
        do_reset();
        wr(2, 0, 16'hFFFF); wr(2, 2, 16'hFFFF); wr(2, 6, 3); wr(2, 7, 1);
        tick_chk("R5 sat t1", 1'b1, 2);
        tick_chk("R5 sat t2", 1'b1, 2);
        wr(2, 2, 16'hFFFE);
        tick_chk("R5 no wrap", 1'b0, 0);
        chk("R5 elig", 32'(elig_o), 0);
        wr(2, 1, 1);
        tick_chk("R4 drain pending", 1'b0, 0);
        tick_chk("R4 drained", 1'b1, 2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule